// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block times a single analog-to-digital conversion. A start pulse launches a run. The block then derives a conversion-clock enable from one of four clock sources and divides it by a programmable power of two. Using that conversion clock, it counts a sample phase and then a convert phase. When the run finishes it raises a one-cycle done strobe. The analog front end and the result path sit outside the block. They use `sample_o`, `convert_o` and `conv_clk_en_o` to pace their own work.

All configuration inputs are captured on the cycle a start is accepted. They stay fixed for the whole run. The source-clock divider and the bus-half toggle both restart from zero on every accepted start, so a given configuration always produces the same cycle count. A channel code of all ones marks the converter as switched off, and a start given with that code is ignored.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is asserted and after reset, with no start, `busy_o`, `sample_o`, `convert_o`, `done_o` and `conv_clk_en_o` are all low.
- R2: A `start_i` seen on a clock edge while idle, with `chan_i` not all ones, makes `busy_o` and `sample_o` high from the next cycle.
- R3: `div_sel_i` codes 0, 1, 2 and 3 give a conversion clock of one tick per 1, 2, 4 and 8 source ticks. The source ticks are counted from the accepted start.
- R4: `clk_src_i` selects the source tick. Code 0 is every cycle. Code 1 is every second busy cycle, beginning with the second. Code 2 is `alt_tick_i` and code 3 is `async_tick_i`.
- R5: The sample phase lasts 4 conversion-clock ticks when `long_smp_i` is 0. When `long_smp_i` is 1, `long_len_i` codes 0, 1, 2 and 3 give 24, 16, 10 and 6 ticks.
- R6: The convert phase lasts N+2 ticks, plus 2 more when `high_speed_i` is 1. N is set by `res_mode_i`: code 0 gives 8, code 1 gives 12, code 2 gives 10, and the reserved code 3 gives 12.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last convert tick. `busy_o` falls in that same cycle.
- R8: While busy, a further `start_i` and changes to any configuration input have no effect on the running conversion's timing.
- R9: A start with `chan_i` all ones is ignored, and `busy_o` stays low.
- R10: `sample_o` and `convert_o` are never high together, and `conv_clk_en_o` is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (bus clock) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| chan_i | input | 5 | Channel code; all ones means switched off |
| clk_src_i | input | 2 | Source tick select |
| div_sel_i | input | 2 | Divide ratio code |
| long_smp_i | input | 1 | Long sample enable |
| long_len_i | input | 2 | Long sample length code |
| high_speed_i | input | 1 | Adds two convert ticks |
| res_mode_i | input | 2 | Resolution code |
| alt_tick_i | input | 1 | Alternate source tick |
| async_tick_i | input | 1 | Asynchronous source tick (already synchronised) |
| conv_clk_en_o | output | 1 | Conversion clock enable |
| sample_o | output | 1 | Sample phase active |
| convert_o | output | 1 | Convert phase active |
| done_o | output | 1 | Conversion done strobe |
| busy_o | output | 1 | Conversion in progress |

## Verification
The busy and sample flags appear one cycle after the edge that accepts a start. `conv_clk_en_o` is combinational within the cycle whose source tick completes a divide period. The phase changes and the done strobe take effect one cycle after that tick. The bench keeps a behavioural model that counts busy cycles, source ticks and conversion ticks as integers. The model advances on the rising edge, and all five outputs are compared with it on the falling edge of every cycle. For the bus-clock sources, the bench also checks the total busy time against the closed form (sample+convert ticks)×ratio×period.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int LEN_W     = 5;
  localparam int SHORT_SMP = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_SAMPLE, PH_CONV} phase_e;
  typedef enum logic [1:0] {SRC_BUS = 2'd0, SRC_BUS_HALF = 2'd1,
                            SRC_ALT = 2'd2, SRC_ASYNC = 2'd3} src_e;

  function automatic logic [LEN_W-1:0] smp_len(input logic long_sel, input logic [1:0] code);
    logic [LEN_W-1:0] extra;
    case (code)
      2'd0:    extra = LEN_W'(20);
      2'd1:    extra = LEN_W'(12);
      2'd2:    extra = LEN_W'(6);
      default: extra = LEN_W'(2);
    endcase
    return long_sel ? LEN_W'(SHORT_SMP) + extra : LEN_W'(SHORT_SMP);
  endfunction

  function automatic logic [LEN_W-1:0] conv_len(input logic [1:0] mode, input logic hs);
    logic [LEN_W-1:0] bits;
    case (mode)
      2'd0:    bits = LEN_W'(8);
      2'd2:    bits = LEN_W'(10);
      default: bits = LEN_W'(12);  // reserved code runs as 12-bit
    endcase
    return bits + LEN_W'(2) + (hs ? LEN_W'(2) : LEN_W'(0));
  endfunction
endpackage

// File: rtl/adc_seq_src_sel.sv
module adc_seq_src_sel
  import adc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] src_i,
  input  logic       alt_tick_i,
  input  logic       async_tick_i,
  output logic       tick_o
);
  logic half_q;
  logic raw_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        half_q <= 1'b0;
    else if (restart_i) half_q <= 1'b0;
    else if (run_i)     half_q <= ~half_q;
  end

  always_comb begin
    case (src_e'(src_i))
      SRC_BUS:      raw_tick = 1'b1;
      SRC_BUS_HALF: raw_tick = half_q;
      SRC_ALT:      raw_tick = alt_tick_i;
      default:      raw_tick = async_tick_i;
    endcase
  end

  assign tick_o = run_i & raw_tick;

  p_half_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !half_q);
endmodule

// File: rtl/adc_seq_clk_div.sv
module adc_seq_clk_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             src_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CW = (1 << DIV_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_val;

  assign last_val = CW'((1 << div_i) - 1);
  assign tick_o   = src_tick_i && (cnt_q == last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (src_tick_i) cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
  end

  p_div_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_val);
  p_div_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/adc_seq_phase_ctr.sv
module adc_seq_phase_ctr
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] smp_len_i,
  input  logic [LEN_W-1:0] conv_len_i,
  output logic             sample_o,
  output logic             convert_o,
  output logic             done_o,
  output logic             busy_o
);
  phase_e           phase_q;
  logic [LEN_W-1:0] cyc_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cyc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept_i) begin
          phase_q <= PH_SAMPLE;
          cyc_q   <= '0;
        end
        PH_SAMPLE: if (tick_i) begin
          if (cyc_q == smp_len_i - LEN_W'(1)) begin
            phase_q <= PH_CONV;
            cyc_q   <= '0;
          end else cyc_q <= cyc_q + LEN_W'(1);
        end
        PH_CONV: if (tick_i) begin
          if (cyc_q == conv_len_i - LEN_W'(1)) begin
            phase_q <= PH_IDLE;
            cyc_q   <= '0;
            done_q  <= 1'b1;
          end else cyc_q <= cyc_q + LEN_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign sample_o  = (phase_q == PH_SAMPLE);
  assign convert_o = (phase_q == PH_CONV);
  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;

  p_first_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sample_o);
  p_done_after_conv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(convert_o)));
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_smp_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> cyc_q < smp_len_i);
  p_conv_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convert_o |-> cyc_q < conv_len_i);
  p_phase_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, convert_o}));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [1:0]       clk_src_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             long_smp_i,
  input  logic [1:0]       long_len_i,
  input  logic             high_speed_i,
  input  logic [1:0]       res_mode_i,
  input  logic             alt_tick_i,
  input  logic             async_tick_i,
  output logic             conv_clk_en_o,
  output logic             sample_o,
  output logic             convert_o,
  output logic             done_o,
  output logic             busy_o
);
  logic             accept;
  logic             src_tick;
  logic             adck_tick;
  logic [1:0]       src_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] smp_q;
  logic [LEN_W-1:0] conv_q;

  assign accept = start_i && !busy_o && (chan_i != '1);

  // configuration frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      div_q  <= '0;
      smp_q  <= LEN_W'(SHORT_SMP);
      conv_q <= LEN_W'(10);
    end else if (accept) begin
      src_q  <= clk_src_i;
      div_q  <= div_sel_i;
      smp_q  <= smp_len(long_smp_i, long_len_i);
      conv_q <= conv_len(res_mode_i, high_speed_i);
    end
  end

  adc_seq_src_sel u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (busy_o),
    .restart_i    (accept),
    .src_i        (src_q),
    .alt_tick_i   (alt_tick_i),
    .async_tick_i (async_tick_i),
    .tick_o       (src_tick)
  );

  adc_seq_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (accept),
    .src_tick_i (src_tick),
    .div_i      (div_q),
    .tick_o     (adck_tick)
  );

  adc_seq_phase_ctr u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .tick_i     (adck_tick),
    .smp_len_i  (smp_q),
    .conv_len_i (conv_q),
    .sample_o   (sample_o),
    .convert_o  (convert_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  assign conv_clk_en_o = adck_tick;

  p_off_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && chan_i == '1 && !busy_o) |=> !busy_o);
  p_tick_in_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_clk_en_o |-> busy_o);
  p_cfg_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(smp_q) && $stable(conv_q) && $stable(div_q) && $stable(src_q)));
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && chan_i != '1 && !busy_o) |=> busy_o);
endmodule

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [4:0] chan_i = 5'd3;
  logic [1:0] clk_src_i = 0, div_sel_i = 0, long_len_i = 0, res_mode_i = 0;
  logic long_smp_i = 0, high_speed_i = 0, alt_tick_i = 0, async_tick_i = 0;
  logic conv_clk_en_o, sample_o, convert_o, done_o, busy_o;

  int tests = 0, fails = 0, cycles = 0;
  bit in_reset = 1, finished = 0;
  int alt_per = 0, async_per = 0, tick_cnt = 0;

  // behavioural reference model
  int m_busy = 0, m_done = 0, m_idx = 0, m_src = 0, m_adck = 0;
  int m_sel = 0, m_ratio = 1, m_smp = 4, m_total = 14;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_conv_seq dut (.*);

  function automatic int f_smp(bit lng, int code);
    int ex[4] = '{20, 12, 6, 2};
    return lng ? 4 + ex[code] : 4;
  endfunction
  function automatic int f_conv(int mode, bit hs);
    int b = (mode == 0) ? 8 : (mode == 2) ? 10 : 12;
    return b + 2 + (hs ? 2 : 0);
  endfunction
  function automatic bit f_tick();
    case (m_sel)
      0: return 1'b1;
      1: return (m_idx % 2) == 1;
      2: return alt_tick_i;
      default: return async_tick_i;
    endcase
  endfunction

  always @(posedge clk_i) begin
    #1;
    tick_cnt++;
    alt_tick_i   = (alt_per > 0) && (tick_cnt % alt_per == 0);
    async_tick_i = (async_per > 0) && (tick_cnt % async_per == 1);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0;
    end else if (m_busy == 0) begin
      m_done = 0;
      if (start_i && chan_i != 5'h1f) begin
        m_busy = 1; m_idx = 0; m_src = 0; m_adck = 0;
        m_sel = clk_src_i; m_ratio = 1 << div_sel_i;
        m_smp = f_smp(long_smp_i, long_len_i);
        m_total = m_smp + f_conv(res_mode_i, high_speed_i);
      end
    end else begin
      m_done = 0;
      if (f_tick()) begin
        m_src++;
        if (m_src % m_ratio == 0) begin
          m_adck++;
          if (m_adck == m_total) begin m_busy = 0; m_done = 1; end
        end
      end
      m_idx++;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!in_reset && !finished) begin
      chk("R2 busy", busy_o, m_busy);
      chk("R5 sample", sample_o, (m_busy != 0) && (m_adck < m_smp));
      chk("R6 convert", convert_o, (m_busy != 0) && (m_adck >= m_smp));
      chk("R7 done", done_o, m_done);
      chk("R3 R4 clk_en", conv_clk_en_o,
          (m_busy != 0) && f_tick() && ((m_src + 1) % m_ratio == 0));
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic launch(int src, int dv, bit lng, int len, bit hs, int mode);
    @(posedge clk_i); #2;
    clk_src_i = src; div_sel_i = dv; long_smp_i = lng; long_len_i = len;
    high_speed_i = hs; res_mode_i = mode; start_i = 1;
    @(posedge clk_i); #2;
    start_i = 0;
  endtask

  task automatic run_and_time(string req, int src, int dv, bit lng, int len, bit hs, int mode);
    int n = 0;
    int exp = (f_smp(lng, len) + f_conv(mode, hs)) * (1 << dv) * ((src == 1) ? 2 : 1);
    launch(src, dv, lng, len, hs, mode);
    @(negedge clk_i);
    while (busy_o) begin n++; @(negedge clk_i); end
    if (src < 2) chk(req, n, exp);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset phases", {sample_o, convert_o, done_o, conv_clk_en_o}, 0);
    @(posedge clk_i); #2 rst_ni = 1;
    repeat (2) @(negedge clk_i);
    in_reset = 0;
    chk("R1 idle", {busy_o, sample_o, convert_o, done_o}, 0);

    run_and_time("R5 R6 short 8-bit", 0, 0, 0, 0, 0, 0);
    run_and_time("R3 R5 R6 div2 long24 12-bit", 0, 1, 1, 0, 0, 1);
    run_and_time("R4 R5 R6 half div4 long16 hs 10-bit", 1, 2, 1, 1, 1, 2);
    run_and_time("R3 R6 div8 long10 reserved", 0, 3, 1, 2, 0, 3);
    alt_per = 3;
    run_and_time("R4 alt", 2, 0, 1, 3, 1, 0);
    async_per = 2;
    run_and_time("R4 async", 3, 1, 0, 0, 0, 1);

    // R8: restart attempt and config change mid-run
    begin
      int n = 0;
      launch(0, 1, 0, 0, 0, 0);
      repeat (5) @(posedge clk_i);
      #2 div_sel_i = 3; long_smp_i = 1; res_mode_i = 1; start_i = 1;
      @(posedge clk_i); #2 start_i = 0;
      @(negedge clk_i);
      while (busy_o) begin n++; @(negedge clk_i); end
      chk("R8 busy span unchanged", n + 6, 14 * 2);
      repeat (3) @(negedge clk_i);
    end

    // R9: switched-off channel
    chan_i = 5'h1f;
    launch(0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    chk("R9 off start ignored", busy_o, 0);
    repeat (20) @(negedge clk_i);
    chk("R9 no done", done_o, 0);
    chan_i = 5'd7;
    run_and_time("R2 after off", 0, 0, 1, 3, 0, 2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule